// File: doc/BRIEF.md
# Burst Memory-to-Memory DMA Engine

This engine copies a block of data from a source region to a destination region. It uses two master ports and a data FIFO between them. Software programs a source address, a destination address, a byte count and an element size, which may be 1, 2, 4, 8 or 16 bytes. Software then sets the go bit in the control register.

The read side fetches elements into the FIFO in bursts, and the write side drains the FIFO to the destination in bursts. No burst is longer than `MAX_BURST` beats, so a long job runs as a train of full bursts followed by one shorter tail burst. The read side only asks for a burst when the FIFO has room for every beat of it. The write side only offers a burst when the FIFO already holds every beat of it.

Either address may be frozen so that it targets a single data register, such as a serial port. Each element size can be removed at build time. A request for a removed size, or for a byte count that does not fit the size, is refused with an error flag. A done flag marks the acceptance of the last write beat.

Top module: `burst_dma`

## Requirements
- R1: After reset the status register reads zero (bit 0 busy, bit 1 done, bit 2 error), `rd_req` and `wr_req` are low, and the length register reads zero.
- R2: The control register (offset 3) has these fields: bits [2:0] select the element size, bit 3 is go, bit 4 fixes the source address and bit 5 fixes the destination address. The size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes. A write with go set does one of two things. If the code is above 4, the code is masked off by `SIZE_EN`, the length is zero, or the length is not a multiple of the size, the error bit is set, busy stays low and no read request is issued. Otherwise busy is set.
- R3: Every burst on either port has a length between 1 and `MAX_BURST`. Bursts of one job are `MAX_BURST` long, except for the last, which carries the remaining beats.
- R4: A read burst is granted only when the FIFO has free entries for all of its beats, so the FIFO never overflows.
- R5: A write burst is granted only when the FIFO holds all of its beats, so the FIFO never underflows.
- R6: Write beats carry the source elements in source order, right-justified on the data bus. `wr_be` has its low N bits set, where N is the element size in bytes. A job moves exactly length/size beats on each port.
- R7: The address of each burst equals the base address plus the beats already issued times the size in bytes. A port whose fixed bit is set repeats its base address and drives `rd_fixed` or `wr_fixed` high.
- R8: The length register (offset 2) drops by the size after each accepted write beat and reads zero when the job ends. After a refused start it still holds the programmed value.
- R9: The done bit is set, and busy is cleared, in the cycle after the final write beat is accepted. Any later write to the control register clears done.
- R10: Register writes while busy have no effect. The source (offset 0), destination (offset 1), length and control registers keep their values.
- R11: A raised `rd_req` or `wr_req` stays high with a stable address and length until its grant is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0 src, 1 dst, 2 length, 3 control, 4 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rd_req | output | 1 | Read burst request |
| rd_addr | output | 32 | Read burst start address |
| rd_len | output | BURST_W | Read burst length in beats |
| rd_fixed | output | 1 | Read burst targets one address |
| rd_gnt | input | 1 | Read burst accepted |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | DATA_W | Read data beat |
| wr_req | output | 1 | Write burst request |
| wr_addr | output | 32 | Write burst start address |
| wr_len | output | BURST_W | Write burst length in beats |
| wr_fixed | output | 1 | Write burst targets one address |
| wr_gnt | input | 1 | Write burst accepted |
| wr_valid | output | 1 | Write data beat valid |
| wr_data | output | DATA_W | Write data beat |
| wr_be | output | DATA_W/8 | Byte enables of the write beat |
| wr_ready | input | 1 | Write beat accepted |

## Verification
The bench builds the engine with `MAX_BURST`=4, `FIFO_DEPTH`=8, `LEN_W`=16, a 128-bit bus, and `SIZE_EN`=5'b10111, which removes the 8-byte size. With these values a 10-beat job splits into 4+4+2 and a 32-beat job runs as eight bursts. A deliberately slow destination fills the FIFO and stalls the reader. A request for the removed size can also be made. All five size codes, both fixed-address options, and lengths that are zero or ragged are covered in these runs.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        SZ_B = 3'd0,
        SZ_H = 3'd1,
        SZ_W = 3'd2,
        SZ_D = 3'd3,
        SZ_Q = 3'd4
    } xsize_e;

    typedef enum logic [2:0] {
        RA_SRC  = 3'd0,
        RA_DST  = 3'd1,
        RA_LEN  = 3'd2,
        RA_CTRL = 3'd3,
        RA_STAT = 3'd4
    } reg_sel_e;

    localparam int CTRL_GO   = 3;
    localparam int CTRL_SFIX = 4;
    localparam int CTRL_DFIX = 5;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        xsize_e      size;
        logic        src_fixed;
        logic        dst_fixed;
    } job_t;

    typedef struct packed {
        logic err;
        logic done;
        logic busy;
    } stat_t;

    function automatic logic [4:0] size_bytes(xsize_e s);
        return 5'd1 << s;
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int         LEN_W   = 16,
    parameter logic [4:0] SIZE_EN = 5'b11111
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             beat_done,
    input  logic             xfer_end,
    output logic             start,
    output job_t             job,
    output logic [LEN_W-1:0] total_beats,
    output stat_t            stat
);

    logic [LEN_W-1:0] len_q;
    job_t             job_q;
    stat_t            stat_q;
    logic             start_q;
    logic [2:0]       code;
    logic [7:0]       en_vec;
    logic             code_ok;
    logic             len_ok;

    always_comb begin
        code    = reg_wdata[2:0];
        en_vec  = {3'b000, SIZE_EN};
        code_ok = (code <= 3'(SZ_Q)) && en_vec[code];
        len_ok  = (len_q != '0) &&
                  ((32'(len_q) & (32'(size_bytes(xsize_e'(code))) - 32'd1)) == 32'd0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= '0;
            job_q   <= '0;
            stat_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (reg_we && !stat_q.busy) begin
                case (reg_sel_e'(reg_addr))
                    RA_SRC: job_q.src <= reg_wdata;
                    RA_DST: job_q.dst <= reg_wdata;
                    RA_LEN: len_q     <= reg_wdata[LEN_W-1:0];
                    RA_CTRL: begin
                        job_q.size      <= xsize_e'(code);
                        job_q.src_fixed <= reg_wdata[CTRL_SFIX];
                        job_q.dst_fixed <= reg_wdata[CTRL_DFIX];
                        stat_q.done     <= 1'b0;
                        stat_q.err      <= 1'b0;
                        if (reg_wdata[CTRL_GO]) begin
                            if (code_ok && len_ok) begin
                                stat_q.busy <= 1'b1;
                                start_q     <= 1'b1;
                            end else begin
                                stat_q.err  <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (stat_q.busy && beat_done)
                len_q <= len_q - LEN_W'(size_bytes(job_q.size));
            if (stat_q.busy && xfer_end) begin
                stat_q.busy <= 1'b0;
                stat_q.done <= 1'b1;
            end
        end
    end

    always_comb begin
        case (reg_sel_e'(reg_addr))
            RA_SRC:  reg_rdata = job_q.src;
            RA_DST:  reg_rdata = job_q.dst;
            RA_LEN:  reg_rdata = 32'(len_q);
            RA_CTRL: reg_rdata = {26'd0, job_q.dst_fixed, job_q.src_fixed, 1'b0, job_q.size};
            RA_STAT: reg_rdata = {29'd0, stat_q};
            default: reg_rdata = 32'd0;
        endcase
    end

    assign start       = start_q;
    assign job         = job_q;
    assign stat        = stat_q;
    assign total_beats = len_q >> job_q.size;

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
    import dma_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int MAX_BURST  = 4,
    parameter int FIFO_DEPTH = 8,
    parameter bit NEED_FILL  = 1'b0,
    localparam int BURST_W   = $clog2(MAX_BURST + 1),
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [31:0]        base,
    input  logic               fixed,
    input  xsize_e             size,
    input  logic [LEN_W-1:0]   total,
    input  logic [CNT_W-1:0]   level,
    input  logic               gnt,
    input  logic               beat,
    output logic               req,
    output logic [31:0]        addr,
    output logic [BURST_W-1:0] len,
    output logic               active,
    output logic               last
);

    logic [LEN_W-1:0]   left_q;
    logic [BURST_W-1:0] rem_q;
    logic [31:0]        addr_q;
    logic               req_q;
    logic [BURST_W-1:0] burst;
    logic               room_ok;

    assign burst = (32'(left_q) >= 32'(MAX_BURST)) ? BURST_W'(MAX_BURST)
                                                   : BURST_W'(left_q);

    generate
        if (NEED_FILL) begin : g_fill
            assign room_ok = 32'(level) >= 32'(burst);
        end else begin : g_space
            assign room_ok = (32'(FIFO_DEPTH) - 32'(level)) >= 32'(burst);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            rem_q  <= '0;
            addr_q <= '0;
            req_q  <= 1'b0;
        end else if (start) begin
            left_q <= total;
            rem_q  <= '0;
            addr_q <= base;
            req_q  <= 1'b0;
        end else begin
            if (!req_q && rem_q == '0 && left_q != '0 && room_ok)
                req_q <= 1'b1;
            if (req_q && gnt) begin
                req_q  <= 1'b0;
                rem_q  <= burst;
                left_q <= left_q - LEN_W'(burst);
                if (!fixed)
                    addr_q <= addr_q + (32'(burst) << size);
            end
            if (beat && rem_q != '0)
                rem_q <= rem_q - BURST_W'(1);
        end
    end

    assign req    = req_q;
    assign addr   = addr_q;
    assign len    = burst;
    assign active = rem_q != '0;
    assign last   = (left_q == '0) && (rem_q == BURST_W'(1));

endmodule

// File: rtl/dma_fifo.sv
module dma_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout  = mem[rp];
    assign count = cnt_q;

endmodule

// File: rtl/burst_dma.sv
module burst_dma
    import dma_pkg::*;
#(
    parameter int         DATA_W     = 128,
    parameter int         LEN_W      = 16,
    parameter int         MAX_BURST  = 4,
    parameter int         FIFO_DEPTH = 8,
    parameter logic [4:0] SIZE_EN    = 5'b11111,
    localparam int        BURST_W    = $clog2(MAX_BURST + 1),
    localparam int        BE_W       = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               rd_req,
    output logic [31:0]        rd_addr,
    output logic [BURST_W-1:0] rd_len,
    output logic               rd_fixed,
    input  logic               rd_gnt,
    input  logic               rd_valid,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               wr_req,
    output logic [31:0]        wr_addr,
    output logic [BURST_W-1:0] wr_len,
    output logic               wr_fixed,
    input  logic               wr_gnt,
    output logic               wr_valid,
    output logic [DATA_W-1:0]  wr_data,
    output logic [BE_W-1:0]    wr_be,
    input  logic               wr_ready
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    job_t             job;
    stat_t            stat;
    logic             start;
    logic [LEN_W-1:0] total_beats;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_push, fifo_pop;
    logic             rd_active, rd_last;
    logic             wr_active, wr_last;
    logic             xfer_end;
    logic             st_busy, st_done, st_err;

    dma_regs #(.LEN_W(LEN_W), .SIZE_EN(SIZE_EN)) regs_i (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .beat_done(fifo_pop), .xfer_end(xfer_end),
        .start(start), .job(job), .total_beats(total_beats), .stat(stat)
    );

    dma_burst_seq #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .FIFO_DEPTH(FIFO_DEPTH),
                    .NEED_FILL(1'b0)) rd_seq_i (
        .clk(clk), .rst(rst), .start(start), .base(job.src), .fixed(job.src_fixed),
        .size(job.size), .total(total_beats), .level(fifo_count), .gnt(rd_gnt),
        .beat(rd_valid), .req(rd_req), .addr(rd_addr), .len(rd_len),
        .active(rd_active), .last(rd_last)
    );

    dma_burst_seq #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .FIFO_DEPTH(FIFO_DEPTH),
                    .NEED_FILL(1'b1)) wr_seq_i (
        .clk(clk), .rst(rst), .start(start), .base(job.dst), .fixed(job.dst_fixed),
        .size(job.size), .total(total_beats), .level(fifo_count), .gnt(wr_gnt),
        .beat(fifo_pop), .req(wr_req), .addr(wr_addr), .len(wr_len),
        .active(wr_active), .last(wr_last)
    );

    dma_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst(rst), .push(fifo_push), .din(rd_data),
        .pop(fifo_pop), .dout(wr_data), .count(fifo_count)
    );

    assign fifo_push = rd_valid && rd_active;
    assign wr_valid  = wr_active;
    assign fifo_pop  = wr_valid && wr_ready;
    assign xfer_end  = fifo_pop && wr_last;
    assign rd_fixed  = job.src_fixed;
    assign wr_fixed  = job.dst_fixed;
    assign wr_be     = BE_W'((32'd1 << size_bytes(job.size)) - 32'd1);
    assign st_busy   = stat.busy;
    assign st_done   = stat.done;
    assign st_err    = stat.err;

    logic unused_ok;
    assign unused_ok = rd_last;

endmodule

// File: rtl/dma_checker.sv
module dma_checker #(
    parameter int MAX_BURST  = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int BURST_W    = 3,
    parameter int CNT_W      = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_req,
    input logic               rd_gnt,
    input logic [31:0]        rd_addr,
    input logic [BURST_W-1:0] rd_len,
    input logic               wr_req,
    input logic               wr_gnt,
    input logic [31:0]        wr_addr,
    input logic [BURST_W-1:0] wr_len,
    input logic               wr_valid,
    input logic               wr_ready,
    input logic [CNT_W-1:0]   fifo_count,
    input logic               fifo_push,
    input logic               st_busy,
    input logic               st_done,
    input logic               st_err
);

    p_rd_burst_cap_r3: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_len != '0) && (32'(rd_len) <= MAX_BURST));

    p_wr_burst_cap_r3: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (wr_len != '0) && (32'(wr_len) <= MAX_BURST));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> 32'(fifo_count) < FIFO_DEPTH);

    p_rd_room_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_gnt) |-> (32'(FIFO_DEPTH) - 32'(fifo_count)) >= 32'(rd_len));

    p_wr_fill_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_gnt) |-> 32'(fifo_count) >= 32'(wr_len));

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |-> fifo_count != '0);

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_gnt) |=> rd_req && $stable(rd_addr) && $stable(rd_len));

    p_wr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_gnt) |=> wr_req && $stable(wr_addr) && $stable(wr_len));

    p_err_idle_r2: assert property (@(posedge clk) disable iff (rst)
        st_err |-> !st_busy);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(st_done) |-> !st_busy);

endmodule

bind burst_dma dma_checker #(
    .MAX_BURST(MAX_BURST), .FIFO_DEPTH(FIFO_DEPTH), .BURST_W(BURST_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_addr(rd_addr), .rd_len(rd_len),
    .wr_req(wr_req), .wr_gnt(wr_gnt), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .fifo_count(fifo_count), .fifo_push(fifo_push),
    .st_busy(st_busy), .st_done(st_done), .st_err(st_err)
);

// File: tb/burst_dma_tb_top.sv
module burst_dma_tb_top;

    localparam int DW   = 128;
    localparam int MAXB = 4;
    localparam int DEP  = 8;
    localparam int BW   = $clog2(MAXB + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [31:0]   reg_wdata = 32'd0;
    logic [31:0]   reg_rdata;
    logic          rd_req, rd_fixed, wr_req, wr_fixed, wr_valid;
    logic [31:0]   rd_addr, wr_addr;
    logic [BW-1:0] rd_len, wr_len;
    logic          rd_gnt = 1'b0, rd_valid = 1'b0, wr_gnt = 1'b0, wr_ready = 1'b0;
    logic [DW-1:0] rd_data = '0, wr_data;
    logic [15:0]   wr_be;

    always #10 clk = ~clk;

    burst_dma #(.DATA_W(DW), .LEN_W(16), .MAX_BURST(MAXB), .FIFO_DEPTH(DEP),
                .SIZE_EN(5'b10111)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len), .rd_fixed(rd_fixed),
        .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_len(wr_len), .wr_fixed(wr_fixed),
        .wr_gnt(wr_gnt), .wr_valid(wr_valid), .wr_data(wr_data), .wr_be(wr_be),
        .wr_ready(wr_ready)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(input logic [31:0] a);
        logic [31:0] h;
        h = (a * 32'h9E3779B1) ^ 32'h5A5A5A5A;
        return {h, ~h, h + 32'd1, a};
    endfunction

    // job context shared with the slave models
    logic [31:0] cur_src = 0, cur_dst = 0;
    int          cur_bytes = 1, total = 0;
    bit          sfix = 0, dfix = 0, slow = 0;
    int          rd_issued = 0, rd_ret = 0, wr_acc = 0, wr_issued = 0;
    int          rpend = 0, rlat = 0, rlen_l = 0, wrem = 0, wlen_l = 0, wcyc = 0;

    function automatic int min_b(input int rem);
        return (rem > MAXB) ? MAXB : rem;
    endfunction

    // source slave
    initial begin
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (rst) begin
                rd_gnt = 1'b0; rpend = 0;
            end else if (rd_gnt) begin
                rd_gnt = 1'b0; rpend = rlen_l; rlat = 2;
            end else if (rpend > 0) begin
                if (rlat > 0) rlat--;
                else begin
                    rd_valid = 1'b1;
                    rd_data  = pat(sfix ? cur_src : cur_src + 32'(rd_ret * cur_bytes));
                    rd_ret++; rpend--;
                end
            end else if (rd_req) begin
                chk(rd_addr == (sfix ? cur_src : cur_src + 32'(rd_issued * cur_bytes)),
                    "R7 read burst address", 128'(rd_addr),
                    128'(sfix ? cur_src : cur_src + 32'(rd_issued * cur_bytes)));
                chk(rd_fixed == sfix, "R7 rd_fixed", 128'(rd_fixed), 128'(sfix));
                chk(int'(rd_len) == min_b(total - rd_issued), "R3 read burst length",
                    128'(rd_len), 128'(min_b(total - rd_issued)));
                chk(rd_issued + int'(rd_len) - wr_acc <= DEP, "R4 FIFO room at read grant",
                    128'(rd_issued + int'(rd_len) - wr_acc), 128'(DEP));
                rd_gnt = 1'b1; rlen_l = int'(rd_len); rd_issued += int'(rd_len);
            end
        end
    end

    // destination slave
    initial begin
        forever begin
            @(negedge clk);
            wcyc++;
            wr_ready = 1'b0;
            if (rst) begin
                wr_gnt = 1'b0; wrem = 0;
            end else if (wr_gnt) begin
                wr_gnt = 1'b0; wrem = wlen_l;
            end else if (wrem > 0) begin
                wr_ready = slow ? (wcyc % 4 == 0) : (wcyc % 3 != 1);
                if (wr_ready && wr_valid) begin
                    logic [127:0] m, e;
                    m = (128'd1 << (8 * cur_bytes)) - 128'd1;
                    e = pat(sfix ? cur_src : cur_src + 32'(wr_acc * cur_bytes));
                    chk((wr_data & m) == (e & m), "R6 write data", wr_data & m, e & m);
                    chk(wr_be == 16'((32'd1 << cur_bytes) - 1), "R6 byte enables",
                        128'(wr_be), 128'((32'd1 << cur_bytes) - 1));
                    wr_acc++; wrem--;
                end
            end else if (wr_req) begin
                chk(wr_addr == (dfix ? cur_dst : cur_dst + 32'(wr_issued * cur_bytes)),
                    "R7 write burst address", 128'(wr_addr),
                    128'(dfix ? cur_dst : cur_dst + 32'(wr_issued * cur_bytes)));
                chk(wr_fixed == dfix, "R7 wr_fixed", 128'(wr_fixed), 128'(dfix));
                chk(int'(wr_len) == min_b(total - wr_issued), "R3 write burst length",
                    128'(wr_len), 128'(min_b(total - wr_issued)));
                chk(rd_ret - wr_acc >= int'(wr_len), "R5 FIFO fill at write grant",
                    128'(rd_ret - wr_acc), 128'(wr_len));
                wr_gnt = 1'b1; wlen_l = int'(wr_len); wr_issued += int'(wr_len);
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int n = 0;
        s = 32'd1;
        while (s[0] && n < 5000) begin
            reg_rd(3'd4, s);
            n++;
        end
        if (n >= 5000) chk(1'b0, "watchdog wait_idle", 128'(n), 128'(0));
    endtask

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] len;
        logic [2:0]  code;
        logic        sfix;
        logic        dfix;
        logic        slow;
        logic        bad;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h1000, 32'h8000, 16'd40, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h2001, 32'h9001, 16'd7,  3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h3000, 32'hA000, 16'd64, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h4000, 32'hB000, 16'd12, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h5000, 32'hC000, 16'd16, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h5100, 32'hC100, 16'd24, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h5200, 32'hC200, 16'd10, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h5300, 32'hC300, 16'd0,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h5400, 32'hC400, 16'd32, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h6000, 32'hD000, 16'd32, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic launch(input vec_t v);
        cur_src = v.src; cur_dst = v.dst; cur_bytes = 1 << v.code;
        sfix = v.sfix; dfix = v.dfix; slow = v.slow;
        total = v.bad ? 0 : int'(v.len) / cur_bytes;
        rd_issued = 0; rd_ret = 0; wr_acc = 0; wr_issued = 0;
        reg_wr(3'd0, v.src);
        reg_wr(3'd1, v.dst);
        reg_wr(3'd2, 32'(v.len));
        reg_wr(3'd3, {26'd0, v.dfix, v.sfix, 1'b1, v.code});
    endtask

    task automatic finish_vec(input vec_t v);
        logic [31:0] s, l;
        wait_idle();
        reg_rd(3'd4, s);
        chk(s[2] == v.bad, "R2 error bit", 128'(s[2]), 128'(v.bad));
        chk(s[1] == !v.bad, "R9 done bit", 128'(s[1]), 128'(!v.bad));
        reg_rd(3'd2, l);
        chk(l == (v.bad ? 32'(v.len) : 32'd0), "R8 length register at end",
            128'(l), 128'(v.bad ? 32'(v.len) : 32'd0));
        chk(rd_issued == total && rd_ret == total, "R6 read beat count",
            128'(rd_ret), 128'(total));
        chk(wr_acc == total, "R6 write beat count", 128'(wr_acc), 128'(total));
        if (v.bad) chk(rd_issued == 0, "R2 no read after refusal", 128'(rd_issued), 128'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        reg_rd(3'd4, d);
        chk(d == 32'd0, "R1 status after reset", 128'(d), 128'(0));
        reg_rd(3'd2, d);
        chk(d == 32'd0, "R1 length after reset", 128'(d), 128'(0));
        chk(!rd_req && !wr_req, "R1 requests idle", 128'({rd_req, wr_req}), 128'(0));

        // table-driven jobs
        for (int i = 0; i < NV; i++) begin
            launch(VECS[i]);
            finish_vec(VECS[i]);
        end

        // R9: a control write clears done
        reg_wr(3'd3, 32'd0);
        reg_rd(3'd4, d);
        chk(d[1] == 1'b0, "R9 done cleared by control write", 128'(d[1]), 128'(0));

        // R10: writes while busy are ignored
        begin
            vec_t v;
            v = '{32'h7000, 32'hE000, 16'd32, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0};
            launch(v);
            repeat (6) @(negedge clk);
            reg_wr(3'd0, 32'hDEADBEEF);
            reg_wr(3'd2, 32'd5);
            reg_wr(3'd3, 32'h0000_0034);
            reg_rd(3'd0, d);
            chk(d == 32'h7000, "R10 source kept while busy", 128'(d), 128'(32'h7000));
            reg_rd(3'd4, d);
            chk(d[0] == 1'b1, "R10 still busy after control write", 128'(d[0]), 128'(1));
            reg_rd(3'd3, d);
            chk(d[2:0] == 3'd0 && d[4] == 1'b0, "R10 control kept while busy",
                128'(d), 128'(0));
            finish_vec(v);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule